// File: doc/BRIEF.md
# Transaction-ID Response Checker

This block pairs predicted transactions with the responses that later come back from a bus whose responses may be reordered. Each prediction carries a transaction ID, an address and a data word. The record goes into a table entry selected directly by a key built from the ID, and that entry is marked occupied. When a response arrives, the entry for its key is read, the payloads are compared, and the entry is released. Because pairing follows the key and not arrival order, responses may return in any order without causing false mismatches.

The key can be the ID alone, or the port number joined above the ID so that several ports share one table. A second build option keeps separate write and read tables, chosen by a channel bit, for buses whose write and read ID spaces overlap. Saturating counters record matches, mismatches, responses with no prediction, and repeated predictions. An end-of-test strobe reports how many entries are still occupied and raises an error if any remain, because a leftover entry means a response never arrived.

Top module: `idmatch_checker`

## Requirements
- R1: A response is paired only with the entry for its own key, whatever order responses arrive in; an equal payload gives a one-cycle `match_pulse` in the cycle after `act_valid` and increments `match_cnt`.
- R2: A response that finds an occupied entry compares both address and data; any difference gives a one-cycle `mismatch_pulse` and increments `mismatch_cnt`. The entry is released after a match or a mismatch, so a second response with the same key is treated as unexpected.
- R3: A response whose key has no occupied entry gives a one-cycle `unexp_pulse` in the cycle after `act_valid`, increments `unexp_cnt`, and leaves every table entry unchanged.
- R4: A prediction for a key whose entry is already occupied gives a one-cycle `dup_pulse` in the cycle after `exp_valid` and increments `dup_cnt`; the new payload replaces the old one.
- R5: The key keeps every bit of the `ID_W`-bit ID, so IDs that differ only in their most significant bit use separate entries.
- R6: With `USE_PORT` set, the key is {port, id}, so the same ID on two ports uses two separate entries.
- R7: With `SPLIT_RW` set, channel 0 (write) and channel 1 (read) use separate tables, so the same key on the two channels uses two separate entries.
- R8: When a prediction and a response target the same key in one cycle, the response is checked against the entry as it was before that cycle, the new record is then stored and left occupied, and no duplicate is reported.
- R9: One cycle after `eot_req`, `eot_done` pulses, `pending_cnt` holds the number of entries that were occupied in the `eot_req` cycle (held until the next request), and `eot_error` pulses exactly when that number is not zero.
- R10: Each of the four event counters stops at 2^`CNT_W`-1 and does not wrap.
- R11: A synchronous active-high `rst` releases all entries and clears every counter, pulse and `pending_cnt`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exp_valid | input | 1 | Prediction strobe |
| exp_chan | input | 1 | Prediction channel, 0 write, 1 read |
| exp_port | input | PORT_W | Prediction port number |
| exp_id | input | ID_W | Prediction transaction ID |
| exp_addr | input | ADDR_W | Predicted address |
| exp_data | input | DATA_W | Predicted data |
| act_valid | input | 1 | Response strobe |
| act_chan | input | 1 | Response channel, 0 write, 1 read |
| act_port | input | PORT_W | Response port number |
| act_id | input | ID_W | Response transaction ID |
| act_addr | input | ADDR_W | Observed address |
| act_data | input | DATA_W | Observed data |
| eot_req | input | 1 | End-of-test request |
| match_pulse | output | 1 | Response matched its entry |
| mismatch_pulse | output | 1 | Response payload differed from its entry |
| unexp_pulse | output | 1 | Response had no occupied entry |
| dup_pulse | output | 1 | Prediction hit an occupied entry |
| match_cnt | output | CNT_W | Saturating match count |
| mismatch_cnt | output | CNT_W | Saturating mismatch count |
| unexp_cnt | output | CNT_W | Saturating unexpected-response count |
| dup_cnt | output | CNT_W | Saturating duplicate-prediction count |
| pending_cnt | output | ID_W+PORT_W+2 | Occupied entries at the last end-of-test request |
| eot_done | output | 1 | End-of-test report valid |
| eot_error | output | 1 | Entries were left over at end of test |

## Verification
The bench builds the block with a 3-bit ID, a 2-bit port, both the composite key and the split tables enabled, and 4-bit counters. The narrow ID puts IDs 1 and 5, which differ only in the top bit, side by side for the truncation case, and lets the three-transaction reorder use IDs 2, 5 and 1. Four-bit counters make saturation reachable with seventeen stray responses, and enabling both key options lets a single build exercise port separation and channel separation against a reference model that keys an associative array by an integer computed from channel, port and ID.

// File: rtl/idm_pkg.sv
package idm_pkg;

  // Outcome of one response lookup.
  typedef enum logic [1:0] {
    RES_NONE     = 2'd0,
    RES_MATCH    = 2'd1,
    RES_MISMATCH = 2'd2,
    RES_UNEXP    = 2'd3
  } act_result_e;

  // Classify a response from its strobe, the entry state and the compare.
  function automatic act_result_e classify(input logic valid, input logic hit,
                                           input logic same);
    if (!valid)     return RES_NONE;
    else if (!hit)  return RES_UNEXP;
    else if (same)  return RES_MATCH;
    else            return RES_MISMATCH;
  endfunction

endpackage

// File: rtl/idm_table.sv
// Direct-mapped table: one occupancy bit and one payload per key.
module idm_table #(
  parameter int KEY_W = 5,
  parameter int PAY_W = 32,
  localparam int DEPTH = 1 << KEY_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [KEY_W-1:0] wr_key,
  input  logic [PAY_W-1:0] wr_pay,
  input  logic             clr_en,
  input  logic [KEY_W-1:0] clr_key,
  input  logic [KEY_W-1:0] rda_key,
  output logic             rda_valid,
  output logic [PAY_W-1:0] rda_pay,
  input  logic [KEY_W-1:0] rdb_key,
  output logic             rdb_valid,
  output logic [DEPTH-1:0] valid_vec
);

  logic [DEPTH-1:0] occ;
  logic [PAY_W-1:0] pay_mem [DEPTH];

  // Release first, then store: a same-key store leaves the entry occupied.
  always_ff @(posedge clk) begin
    if (rst) begin
      occ <= '0;
    end else begin
      if (clr_en) occ[clr_key] <= 1'b0;
      if (wr_en)  occ[wr_key]  <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) pay_mem[wr_key] <= wr_pay;
  end

  assign rda_valid = occ[rda_key];
  assign rda_pay   = pay_mem[rda_key];
  assign rdb_valid = occ[rdb_key];
  assign valid_vec = occ;

endmodule

// File: rtl/idm_satcnt.sv
// Event counter that stops at its maximum value.
module idm_satcnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  output logic [W-1:0] count
);

  function automatic logic [W-1:0] sat_next(input logic [W-1:0] c);
    return (&c) ? c : c + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (rst)      count <= '0;
    else if (inc) count <= sat_next(count);
  end

endmodule

// File: rtl/idm_popcount.sv
// Number of set bits in a vector.
module idm_popcount #(
  parameter int N = 64,
  parameter int W = 7
) (
  input  logic [N-1:0] vec,
  output logic [W-1:0] count
);

  always_comb begin
    count = '0;
    for (int i = 0; i < N; i++) count = count + W'(vec[i]);
  end

endmodule

// File: rtl/idmatch_checker.sv
module idmatch_checker #(
  parameter int ID_W     = 4,
  parameter int PORT_W   = 2,
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 16,
  parameter int CNT_W    = 8,
  parameter bit USE_PORT = 1'b1,
  parameter bit SPLIT_RW = 1'b1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   exp_valid,
  input  logic                   exp_chan,
  input  logic [PORT_W-1:0]      exp_port,
  input  logic [ID_W-1:0]        exp_id,
  input  logic [ADDR_W-1:0]      exp_addr,
  input  logic [DATA_W-1:0]      exp_data,
  input  logic                   act_valid,
  input  logic                   act_chan,
  input  logic [PORT_W-1:0]      act_port,
  input  logic [ID_W-1:0]        act_id,
  input  logic [ADDR_W-1:0]      act_addr,
  input  logic [DATA_W-1:0]      act_data,
  input  logic                   eot_req,
  output logic                   match_pulse,
  output logic                   mismatch_pulse,
  output logic                   unexp_pulse,
  output logic                   dup_pulse,
  output logic [CNT_W-1:0]       match_cnt,
  output logic [CNT_W-1:0]       mismatch_cnt,
  output logic [CNT_W-1:0]       unexp_cnt,
  output logic [CNT_W-1:0]       dup_cnt,
  output logic [ID_W+PORT_W+1:0] pending_cnt,
  output logic                   eot_done,
  output logic                   eot_error
);
  import idm_pkg::*;

  localparam int KEY_W  = ID_W + (USE_PORT ? PORT_W : 0);
  localparam int NTAB   = SPLIT_RW ? 2 : 1;
  localparam int DEPTH  = 1 << KEY_W;
  localparam int PAY_W  = ADDR_W + DATA_W;
  localparam int TOT    = NTAB * DEPTH;
  localparam int PEND_W = ID_W + PORT_W + 2;

  // Key and table selection
  logic [KEY_W-1:0] exp_key, act_key;
  logic             exp_tsel, act_tsel;

  if (USE_PORT) begin : g_key_port
    assign exp_key = {exp_port, exp_id};
    assign act_key = {act_port, act_id};
  end else begin : g_key_id
    assign exp_key = exp_id;
    assign act_key = act_id;
  end

  if (SPLIT_RW) begin : g_sel_split
    assign exp_tsel = exp_chan;
    assign act_tsel = act_chan;
  end else begin : g_sel_single
    assign exp_tsel = 1'b0;
    assign act_tsel = 1'b0;
  end

  // Named internal events, brought out for the checker
  logic             ev_hit, ev_same, ev_dup, ev_clash;
  logic             ev_match, ev_mismatch, ev_unexp;
  act_result_e      act_res;
  logic [PAY_W-1:0] exp_pay, act_pay;

  assign exp_pay = {exp_addr, exp_data};
  assign act_pay = {act_addr, act_data};

  // Table instances
  logic             tab_act_valid [NTAB];
  logic [PAY_W-1:0] tab_act_pay   [NTAB];
  logic             tab_exp_valid [NTAB];
  logic [DEPTH-1:0] tab_vec       [NTAB];
  logic [TOT-1:0]   all_valid;

  for (genvar t = 0; t < NTAB; t++) begin : g_tab
    idm_table #(.KEY_W(KEY_W), .PAY_W(PAY_W)) u_tab (
      .clk       (clk),
      .rst       (rst),
      .wr_en     (exp_valid && (int'(exp_tsel) == t)),
      .wr_key    (exp_key),
      .wr_pay    (exp_pay),
      .clr_en    (ev_hit && (int'(act_tsel) == t)),
      .clr_key   (act_key),
      .rda_key   (act_key),
      .rda_valid (tab_act_valid[t]),
      .rda_pay   (tab_act_pay[t]),
      .rdb_key   (exp_key),
      .rdb_valid (tab_exp_valid[t]),
      .valid_vec (tab_vec[t])
    );
    assign all_valid[t*DEPTH +: DEPTH] = tab_vec[t];
  end

  // Lookup and compare against the registered entry
  assign ev_hit   = act_valid && tab_act_valid[act_tsel];
  assign ev_same  = (tab_act_pay[act_tsel] == act_pay);
  assign act_res  = classify(act_valid, tab_act_valid[act_tsel], ev_same);
  assign ev_match    = (act_res == RES_MATCH);
  assign ev_mismatch = (act_res == RES_MISMATCH);
  assign ev_unexp    = (act_res == RES_UNEXP);

  // A response consuming the same entry this cycle cancels the duplicate.
  assign ev_clash = ev_hit && (exp_tsel == act_tsel) && (exp_key == act_key);
  assign ev_dup   = exp_valid && tab_exp_valid[exp_tsel] && !ev_clash;

  // Saturating event counters
  logic [3:0]       cnt_inc;
  logic [CNT_W-1:0] cnt_val [4];

  assign cnt_inc = {ev_dup, ev_unexp, ev_mismatch, ev_match};

  for (genvar c = 0; c < 4; c++) begin : g_cnt
    idm_satcnt #(.W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst   (rst),
      .inc   (cnt_inc[c]),
      .count (cnt_val[c])
    );
  end

  assign match_cnt    = cnt_val[0];
  assign mismatch_cnt = cnt_val[1];
  assign unexp_cnt    = cnt_val[2];
  assign dup_cnt      = cnt_val[3];

  // Pending count for end of test
  logic [PEND_W-1:0] occ_now;

  idm_popcount #(.N(TOT), .W(PEND_W)) u_pop (
    .vec   (all_valid),
    .count (occ_now)
  );

  // Registered result pulses and end-of-test report
  always_ff @(posedge clk) begin
    if (rst) begin
      match_pulse    <= 1'b0;
      mismatch_pulse <= 1'b0;
      unexp_pulse    <= 1'b0;
      dup_pulse      <= 1'b0;
      eot_done       <= 1'b0;
      eot_error      <= 1'b0;
      pending_cnt    <= '0;
    end else begin
      match_pulse    <= ev_match;
      mismatch_pulse <= ev_mismatch;
      unexp_pulse    <= ev_unexp;
      dup_pulse      <= ev_dup;
      eot_done       <= eot_req;
      eot_error      <= eot_req && (occ_now != '0);
      if (eot_req) pending_cnt <= occ_now;
    end
  end

endmodule

// File: rtl/idm_checker_sva.sv
module idm_checker_sva #(
  parameter int CNT_W  = 8,
  parameter int PEND_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              exp_valid,
  input logic              act_valid,
  input logic              eot_req,
  input logic              match_pulse,
  input logic              mismatch_pulse,
  input logic              unexp_pulse,
  input logic              dup_pulse,
  input logic [CNT_W-1:0]  match_cnt,
  input logic [CNT_W-1:0]  unexp_cnt,
  input logic [PEND_W-1:0] pending_cnt,
  input logic              eot_done,
  input logic              eot_error
);

  localparam logic [CNT_W-1:0] CMAX = '1;

  AST_ONE_RESULT: assert property (@(posedge clk) disable iff (rst)
    $onehot0({match_pulse, mismatch_pulse, unexp_pulse})); // R2

  AST_RESPONSE_RESOLVED: assert property (@(posedge clk) disable iff (rst)
    act_valid |=> (match_pulse || mismatch_pulse || unexp_pulse)); // R1

  AST_RESULT_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && (match_pulse || mismatch_pulse || unexp_pulse)) |-> $past(act_valid)); // R3

  AST_DUP_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && dup_pulse) |-> $past(exp_valid)); // R4

  AST_EOT_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (rst)
    eot_req |=> eot_done); // R9

  AST_EOT_ERROR_CONSISTENT: assert property (@(posedge clk) disable iff (rst)
    eot_done |-> (eot_error == (pending_cnt != '0))); // R9

  AST_MATCH_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && match_pulse && $past(match_cnt) != CMAX)
      |-> (match_cnt == $past(match_cnt) + 1'b1)); // R10

  AST_MATCH_CNT_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(match_cnt) == CMAX) |-> (match_cnt == CMAX)); // R10

  AST_UNEXP_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !unexp_pulse) |-> $stable(unexp_cnt)); // R3

  AST_RESET_CLEARS: assert property (@(posedge clk)
    $past(rst) |-> (match_cnt == '0 && unexp_cnt == '0 && !dup_pulse && !eot_done)); // R11

endmodule

bind idmatch_checker idm_checker_sva #(
  .CNT_W  (CNT_W),
  .PEND_W (ID_W + PORT_W + 2)
) u_sva (
  .clk            (clk),
  .rst            (rst),
  .exp_valid      (exp_valid),
  .act_valid      (act_valid),
  .eot_req        (eot_req),
  .match_pulse    (match_pulse),
  .mismatch_pulse (mismatch_pulse),
  .unexp_pulse    (unexp_pulse),
  .dup_pulse      (dup_pulse),
  .match_cnt      (match_cnt),
  .unexp_cnt      (unexp_cnt),
  .pending_cnt    (pending_cnt),
  .eot_done       (eot_done),
  .eot_error      (eot_error)
);

// File: tb/idmatch_checker_tb.sv
`timescale 1ns/1ps
module idmatch_checker_tb;

  localparam int IW = 3;
  localparam int PW = 2;
  localparam int AW = 16;
  localparam int DW = 16;
  localparam int CW = 4;
  localparam int PNW = IW + PW + 2;
  localparam int CSAT = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst;
  logic exp_valid, exp_chan, act_valid, act_chan, eot_req;
  logic [PW-1:0] exp_port, act_port;
  logic [IW-1:0] exp_id, act_id;
  logic [AW-1:0] exp_addr, act_addr;
  logic [DW-1:0] exp_data, act_data;
  logic match_pulse, mismatch_pulse, unexp_pulse, dup_pulse;
  logic [CW-1:0] match_cnt, mismatch_cnt, unexp_cnt, dup_cnt;
  logic [PNW-1:0] pending_cnt;
  logic eot_done, eot_error;

  always #2.5 clk = ~clk;

  idmatch_checker #(
    .ID_W(IW), .PORT_W(PW), .ADDR_W(AW), .DATA_W(DW), .CNT_W(CW),
    .USE_PORT(1'b1), .SPLIT_RW(1'b1)
  ) u_dut (
    .clk(clk), .rst(rst),
    .exp_valid(exp_valid), .exp_chan(exp_chan), .exp_port(exp_port), .exp_id(exp_id),
    .exp_addr(exp_addr), .exp_data(exp_data),
    .act_valid(act_valid), .act_chan(act_chan), .act_port(act_port), .act_id(act_id),
    .act_addr(act_addr), .act_data(act_data),
    .eot_req(eot_req),
    .match_pulse(match_pulse), .mismatch_pulse(mismatch_pulse),
    .unexp_pulse(unexp_pulse), .dup_pulse(dup_pulse),
    .match_cnt(match_cnt), .mismatch_cnt(mismatch_cnt),
    .unexp_cnt(unexp_cnt), .dup_cnt(dup_cnt),
    .pending_cnt(pending_cnt), .eot_done(eot_done), .eot_error(eot_error)
  );

  // Reference model state
  int unsigned mdl_tab [int];
  int m_match, m_mis, m_unexp, m_dup, m_pend;
  bit e_match, e_mis, e_unexp, e_dup, e_done, e_err;
  int checks = 0;
  int errors = 0;
  string cur_req = "R11";

  function automatic int keyof(input logic ch, input logic [PW-1:0] p, input logic [IW-1:0] i);
    return int'(ch) * (1 << (PW + IW)) + int'(p) * (1 << IW) + int'(i);
  endfunction

  function automatic int sat(input int v);
    return (v >= CSAT) ? CSAT : v + 1;
  endfunction

  // Advance the model by one clock edge using the inputs now applied.
  task automatic model_step();
    int ak, ek;
    bit hit, consumed;
    ak = keyof(act_chan, act_port, act_id);
    ek = keyof(exp_chan, exp_port, exp_id);
    e_match = 0; e_mis = 0; e_unexp = 0; e_dup = 0; e_done = 0; e_err = 0;
    if (rst) begin
      mdl_tab.delete();
      m_match = 0; m_mis = 0; m_unexp = 0; m_dup = 0; m_pend = 0;
      return;
    end
    consumed = 0;
    if (eot_req) begin
      m_pend = mdl_tab.num();
      e_done = 1;
      e_err  = (m_pend != 0);
    end
    if (act_valid) begin
      hit = mdl_tab.exists(ak);
      if (!hit) begin
        e_unexp = 1; m_unexp = sat(m_unexp);
      end else begin
        if (mdl_tab[ak] == {act_addr, act_data}) begin
          e_match = 1; m_match = sat(m_match);
        end else begin
          e_mis = 1; m_mis = sat(m_mis);
        end
        consumed = 1;
      end
    end
    if (exp_valid) begin
      if (mdl_tab.exists(ek) && !(consumed && ek == ak)) begin
        e_dup = 1; m_dup = sat(m_dup);
      end
    end
    if (consumed) mdl_tab.delete(ak);
    if (exp_valid) mdl_tab[ek] = {exp_addr, exp_data};
  endtask

  task automatic chk(input string what, input int act_v, input int exp_v);
    checks++;
    if (act_v != exp_v) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", cur_req, what, act_v, exp_v);
    end
  endtask

  task automatic compare_all();
    chk("match_pulse",    int'(match_pulse),    int'(e_match));
    chk("mismatch_pulse", int'(mismatch_pulse), int'(e_mis));
    chk("unexp_pulse",    int'(unexp_pulse),    int'(e_unexp));
    chk("dup_pulse",      int'(dup_pulse),      int'(e_dup));
    chk("match_cnt",      int'(match_cnt),      m_match);
    chk("mismatch_cnt",   int'(mismatch_cnt),   m_mis);
    chk("unexp_cnt",      int'(unexp_cnt),      m_unexp);
    chk("dup_cnt",        int'(dup_cnt),        m_dup);
    chk("eot_done",       int'(eot_done),       int'(e_done));
    chk("eot_error",      int'(eot_error),      int'(e_err));
    chk("pending_cnt",    int'(pending_cnt),    m_pend);
  endtask

  task automatic idle();
    exp_valid = 0; act_valid = 0; eot_req = 0;
    exp_chan = 0; exp_port = '0; exp_id = '0; exp_addr = '0; exp_data = '0;
    act_chan = 0; act_port = '0; act_id = '0; act_addr = '0; act_data = '0;
  endtask

  task automatic tick();
    model_step();
    @(posedge clk);
    @(negedge clk);
    compare_all();
    idle();
  endtask

  task automatic set_exp(input logic ch, input int p, input int i, input int a, input int d);
    exp_valid = 1; exp_chan = ch; exp_port = PW'(p); exp_id = IW'(i);
    exp_addr = AW'(a); exp_data = DW'(d);
  endtask

  task automatic set_act(input logic ch, input int p, input int i, input int a, input int d);
    act_valid = 1; act_chan = ch; act_port = PW'(p); act_id = IW'(i);
    act_addr = AW'(a); act_data = DW'(d);
  endtask

  task automatic predict(input logic ch, input int p, input int i, input int a, input int d);
    set_exp(ch, p, i, a, d); tick();
  endtask

  task automatic respond(input logic ch, input int p, input int i, input int a, input int d);
    set_act(ch, p, i, a, d); tick();
  endtask

  task automatic end_of_test();
    eot_req = 1; tick();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle();
    rst = 1;
    @(negedge clk);
    // R11: reset state
    cur_req = "R11";
    tick(); tick();
    rst = 0;
    tick();

    // R1: predictions 2,5,1, responses 5,1,2
    cur_req = "R1";
    predict(0, 0, 2, 'h1000, 'h0a02);
    predict(0, 0, 5, 'h2000, 'h0a05);
    predict(0, 0, 1, 'h3000, 'h0a01);
    respond(0, 0, 5, 'h2000, 'h0a05);
    respond(0, 0, 1, 'h3000, 'h0a01);
    respond(0, 0, 2, 'h1000, 'h0a02);
    end_of_test();
    chk("R1 three matches", int'(match_cnt), 3);
    chk("R1 nothing pending", int'(pending_cnt), 0);

    // R2: mismatch frees the entry; repeat response is unexpected
    cur_req = "R2";
    predict(0, 0, 3, 'h4000, 'h1111);
    respond(0, 0, 3, 'h4000, 'h2222);
    respond(0, 0, 3, 'h4000, 'h1111);
    predict(0, 0, 3, 'h4000, 'h1111);
    respond(0, 0, 3, 'h4004, 'h1111);

    // R3: unknown ID leaves other entries intact
    cur_req = "R3";
    predict(0, 0, 4, 'h5000, 'h0404);
    respond(0, 0, 6, 'h5000, 'h0404);
    end_of_test();
    respond(0, 0, 4, 'h5000, 'h0404);

    // R4: duplicate prediction overwrites the payload
    cur_req = "R4";
    predict(0, 0, 0, 'h6000, 'h00aa);
    predict(0, 0, 0, 'h6000, 'h00bb);
    respond(0, 0, 0, 'h6000, 'h00bb);

    // R5: IDs 1 and 5 differ only in the top bit
    cur_req = "R5";
    predict(0, 0, 1, 'h7001, 'h0001);
    predict(0, 0, 5, 'h7005, 'h0005);
    respond(0, 0, 5, 'h7005, 'h0005);
    respond(0, 0, 1, 'h7001, 'h0001);

    // R6: same ID on two ports
    cur_req = "R6";
    predict(0, 1, 2, 'h8100, 'h0012);
    predict(0, 2, 2, 'h8200, 'h0022);
    respond(0, 2, 2, 'h8200, 'h0022);
    respond(0, 1, 2, 'h8100, 'h0012);

    // R7: same key on write and read channels
    cur_req = "R7";
    predict(0, 3, 3, 'h9000, 'h0033);
    predict(1, 3, 3, 'h9800, 'h0133);
    respond(1, 3, 3, 'h9800, 'h0133);
    respond(0, 3, 3, 'h9000, 'h0033);

    // R8: prediction and response on the same key in one cycle
    cur_req = "R8";
    predict(0, 1, 6, 'ha000, 'h0061);
    set_exp(0, 1, 6, 'ha000, 'h0062);
    set_act(0, 1, 6, 'ha000, 'h0061);
    tick();
    respond(0, 1, 6, 'ha000, 'h0062);

    // R9: leftover entry reported, then cleared
    cur_req = "R9";
    predict(1, 0, 7, 'hb000, 'h0077);
    end_of_test();
    chk("R9 one pending", int'(pending_cnt), 1);
    respond(1, 0, 7, 'hb000, 'h0077);
    end_of_test();

    // R10: counters stop at their maximum
    cur_req = "R10";
    for (int n = 0; n < 17; n++) respond(0, 2, 7, 'hc000, n);
    chk("R10 unexp saturated", int'(unexp_cnt), CSAT);
    for (int n = 0; n < 14; n++) begin
      predict(0, 2, 1, 'hd000, n);
      respond(0, 2, 1, 'hd000, n);
    end
    chk("R10 match saturated", int'(match_cnt), CSAT);

    // R11: reset mid-run releases entries
    cur_req = "R11";
    predict(0, 0, 2, 'he000, 'h0002);
    rst = 1; tick();
    rst = 0; tick();
    end_of_test();
    chk("R11 nothing pending after reset", int'(pending_cnt), 0);
    respond(0, 0, 2, 'he000, 'h0002);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule